// File: doc/BRIEF.md
# USB Full-Speed Line Condition Detector

This block observes the D+ and D- wires of a full-speed USB function and recognises the three long-duration bus conditions that a device must react to: a host-driven bus reset, a suspend caused by an idle bus, and a resume when activity returns. The wires are treated as asynchronous. They pass through a two-stage synchronizer, and the resulting line state is then classified on every clock cycle.

Two saturating counters measure how long the bus has held a condition. One counts consecutive single-ended-zero cycles. The other counts consecutive idle (J) cycles. Both thresholds are derived from a clock-frequency parameter: bus reset needs 2.5 µs of SE0, and suspend needs 3 ms of idle. Each detection produces a one-cycle strobe for an interrupt controller. A sticky flag records that the bus is suspended until a K state or a bus reset ends the suspension.

Top module: `usb_line_cond_det`

## Requirements
- R1: Line-state encoding as {dp_i, dm_i} is: J = 2'b10, K = 2'b01, SE0 = 2'b00, SE1 = 2'b11. Both inputs pass through two flip-flops before evaluation. A condition first presented before clock edge 1 is evaluated at edge 3.
- R2: Let RC = ceil(CLK_HZ × 2.5 µs), computed as (CLK_HZ+399999)/400000. If SE0 is presented continuously, starting before edge 1, bus_reset_o is high for exactly one cycle following edge RC+2.
- R3: An SE0 run shorter than RC cycles produces no bus reset. Any other state restarts the SE0 measurement.
- R4: One continuous SE0 period produces at most one bus_reset_o strobe, however long it lasts.
- R5: Let SC = ceil(CLK_HZ × 3 ms), computed as (CLK_HZ*3+999)/1000. If J is presented continuously, starting before edge 1, while not suspended, suspend_o is high for one cycle following edge SC+2, and suspended_o becomes 1 at that same edge.
- R6: K, SE0 and SE1 all restart the idle measurement. An idle run shorter than SC cycles produces no suspend.
- R7: While suspended_o is 1, a K state produces one resume_o strobe at the edge where K is evaluated, and suspended_o clears at that same edge.
- R8: An SE0 shorter than RC while suspended leaves suspended_o set. A full bus reset while suspended clears suspended_o and produces no resume_o strobe.
- R9: K or SE1 while not suspended produces no resume_o strobe.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ receiver output, asynchronous |
| dm_i | input | 1 | D- receiver output, asynchronous |
| bus_reset_o | output | 1 | One-cycle strobe: bus reset recognised |
| suspend_o | output | 1 | One-cycle strobe: suspend recognised |
| resume_o | output | 1 | One-cycle strobe: resume recognised |
| suspended_o | output | 1 | Sticky flag: bus is currently suspended |

## Verification
The bench probes both thresholds at their exact edges. An SE0 or idle run one cycle short must give nothing, and a run of exactly the threshold must raise the strobe in one precise cycle. An off-by-one counter or a missing synchronizer stage would move or suppress that strobe. A long SE0 is held to catch a detector that re-fires after the counter wraps. A short SE0 and a full bus reset are both applied while suspended: a design that treats any SE0 as resume would drop the flag early, and one that routes bus reset through the resume path would emit a spurious resume strobe. K and SE1 are also driven while the bus is active, which exposes a resume detector that ignores the suspended state.

// File: rtl/usb_line_cond_det.sv
module usb_line_cond_det #(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_i,
  input  logic dm_i,
  output logic bus_reset_o,
  output logic suspend_o,
  output logic resume_o,
  output logic suspended_o
);

  localparam int RST_CYC  = (CLK_HZ + 399_999) / 400_000;
  localparam int SUSP_CYC = (CLK_HZ * 3 + 999) / 1000;
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int SW = $clog2(SUSP_CYC + 1);
  localparam logic [RW-1:0] RST_MAX   = RW'(RST_CYC);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_CYC - 1);
  localparam logic [SW-1:0] SUSP_MAX  = SW'(SUSP_CYC);
  localparam logic [SW-1:0] SUSP_LAST = SW'(SUSP_CYC - 1);

  logic [1:0] meta, line;
  logic [RW-1:0] se0_cnt;
  logic [SW-1:0] idle_cnt;

  wire is_se0 = (line == 2'b00);
  wire is_j   = (line == 2'b10);
  wire is_k   = (line == 2'b01);

  wire hit_rst  = is_se0 && (se0_cnt == RST_LAST);
  wire hit_susp = is_j && (idle_cnt == SUSP_LAST) && !suspended_o;
  wire hit_res  = is_k && suspended_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 2'b10;
      line <= 2'b10;
    end else begin
      meta <= {dp_i, dm_i};
      line <= meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_cnt  <= '0;
      idle_cnt <= '0;
    end else begin
      if (!is_se0)                 se0_cnt <= '0;
      else if (se0_cnt != RST_MAX) se0_cnt <= se0_cnt + 1'b1;
      if (!is_j)                     idle_cnt <= '0;
      else if (idle_cnt != SUSP_MAX) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_reset_o <= 1'b0;
      suspend_o   <= 1'b0;
      resume_o    <= 1'b0;
      suspended_o <= 1'b0;
    end else begin
      bus_reset_o <= hit_rst;
      suspend_o   <= hit_susp;
      resume_o    <= hit_res;
      if (hit_rst || hit_res) suspended_o <= 1'b0;
      else if (hit_susp)      suspended_o <= 1'b1;
    end
  end

  p_rst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_o |=> !bus_reset_o);
  p_susp_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> suspended_o);
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended_o) |-> suspend_o);
  p_resume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> (!suspended_o && $past(suspended_o)));
  p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended_o) |-> (resume_o || bus_reset_o));
  p_no_reset_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset_o && resume_o));
  p_strobes_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_reset_o, suspend_o, resume_o}));

endmodule

// File: tb/sim_usb_line_cond_det.sv
module sim_usb_line_cond_det;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CLK_HZ = 4_000_000;
  localparam int  RC = (CLK_HZ + 399_999) / 400_000;
  localparam int  SC = (CLK_HZ * 3 + 999) / 1000;
  localparam logic [1:0] LJ = 2'b10, LK = 2'b01, L0 = 2'b00, L1 = 2'b11;

  localparam int NV = 13;
  // {line, hold, resets, suspends, resumes, flag}; counts relative to loop start
  localparam logic [30:0] TBL [NV] = '{
    {LJ, 16'd100,      4'd0, 4'd0, 4'd0, 1'b0},
    {L0, 16'd5,        4'd0, 4'd0, 4'd0, 1'b0},
    {LJ, 16'd50,       4'd0, 4'd0, 4'd0, 1'b0},
    {L0, 16'd40,       4'd1, 4'd0, 4'd0, 1'b0},
    {LJ, 16'(SC + 10), 4'd1, 4'd1, 4'd0, 1'b1},
    {L0, 16'd3,        4'd1, 4'd1, 4'd0, 1'b1},
    {LJ, 16'd20,       4'd1, 4'd1, 4'd0, 1'b1},
    {LK, 16'd20,       4'd1, 4'd1, 4'd1, 1'b0},
    {LJ, 16'(SC + 10), 4'd1, 4'd2, 4'd1, 1'b1},
    {L0, 16'd40,       4'd2, 4'd2, 4'd1, 1'b0},
    {LJ, 16'd100,      4'd2, 4'd2, 4'd1, 1'b0},
    {L1, 16'd20,       4'd2, 4'd2, 4'd1, 1'b0},
    {LK, 16'd30,       4'd2, 4'd2, 4'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0;
  logic bus_reset_o, suspend_o, resume_o, suspended_o;
  int checks = 0, errors = 0;
  int n_rst = 0, n_susp = 0, n_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_line_cond_det #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
    .bus_reset_o(bus_reset_o), .suspend_o(suspend_o),
    .resume_o(resume_o), .suspended_o(suspended_o));

  always @(negedge clk) if (rst_n) begin
    n_rst  += int'(bus_reset_o);
    n_susp += int'(suspend_o);
    n_res  += int'(resume_o);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] ls, input int n);
    {dp, dm} = ls;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200_000 - 10) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int br, bs, bo;
    repeat (4) @(negedge clk);
    chk("R10 reset outputs", {bus_reset_o, suspend_o, resume_o, suspended_o}, 0);
    rst_n = 1'b1;
    put(LJ, 5);
    chk("R10 after release", {bus_reset_o, suspend_o, resume_o, suspended_o}, 0);

    // R2 exact reset timing, R1 two-stage latency
    put(L0, RC + 1);
    chk("R2 no strobe before edge RC+2", bus_reset_o, 0);
    put(L0, 1);
    chk("R2 strobe at edge RC+2", bus_reset_o, 1);
    put(L0, 1);
    chk("R2 strobe one cycle", bus_reset_o, 0);
    put(L0, 60);
    chk("R4 single reset per SE0 period", n_rst, 1);
    put(LJ, 20);

    // R3 short SE0 runs
    put(L0, RC - 1); put(LJ, 20);
    put(L0, RC - 1); put(LK, 20);
    chk("R3 short SE0 ignored", n_rst, 1);
    put(L0, 4); put(L1, 1); put(L0, RC - 2); put(LJ, 20);
    chk("R3 SE1 restarts SE0 count", n_rst, 1);

    br = n_rst; bs = n_susp; bo = n_res;
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = TBL[i];
      put(v[30:29], int'(v[28:13]));
      chk($sformatf("R2 R4 R8 vec%0d resets", i), n_rst - br, int'(v[12:9]));
      chk($sformatf("R5 R6 vec%0d suspends", i), n_susp - bs, int'(v[8:5]));
      chk($sformatf("R7 R9 vec%0d resumes", i), n_res - bo, int'(v[4:1]));
      chk($sformatf("R8 vec%0d flag", i), suspended_o, int'(v[0]));
    end

    // R5 exact suspend timing
    put(LK, 5);
    put(LJ, SC + 1);
    chk("R5 no suspend before edge SC+2", {suspend_o, suspended_o}, 0);
    put(LJ, 1);
    chk("R5 suspend strobe and flag", {suspend_o, suspended_o}, 3);
    put(LJ, 1);
    chk("R5 strobe one cycle, flag sticky", {suspend_o, suspended_o}, 1);
    put(LJ, 50);
    // R7 exact resume timing
    put(LK, 2);
    chk("R7 no resume before evaluation", {resume_o, suspended_o}, 1);
    put(LK, 1);
    chk("R7 resume strobe, flag cleared", {resume_o, suspended_o}, 2);
    put(LK, 1);
    chk("R7 resume one cycle", resume_o, 0);

    // R6 idle boundary
    bs = n_susp;
    put(LJ, SC - 1); put(LK, 10);
    put(LJ, SC - 1); put(L0, 2); put(LJ, SC - 1); put(L1, 3);
    chk("R6 short idle runs give no suspend", n_susp - bs, 0);
    chk("R6 flag stays clear", suspended_o, 0);

    // R10 reset while suspended
    put(LJ, SC + 5);
    chk("R5 suspended before reset", suspended_o, 1);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears flag", {bus_reset_o, suspend_o, resume_o, suspended_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    put(LJ, 3);
    chk("R10 flag clear after release", suspended_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule